// File: doc/BRIEF.md
# Single-Bus Processor Core with Step-Counter Control

This block is a small 32-bit processor core in which the program counter, the instruction register, the memory address and data registers, the Y and Z temporaries and a sixteen-entry general register file all share one internal bus. Each instruction runs as a series of control steps. In each step at most one source drives the bus and any number of registers capture from it. A hardwired decoder reads the step counter and the opcode and produces the control word. The step counter returns to step 1 when the decoder signals the end of an instruction.

The ALU takes its first operand from a multiplexer. That multiplexer selects either Y or the constant 4. The second operand comes from the bus. The constant path advances the program counter during fetch, and Y keeps the advanced PC as the base for relative branches. Memory is reached through a single port: an address, one-hot read and write requests, write data, read data and a completion pulse. A step that waits for memory holds the sequencer until the completion pulse arrives.

Instruction word: opcode in bits 31:28, destination index in 27:24, first source index in 23:20, second source index in 19:16, and a signed 16-bit immediate or byte offset in 15:0.

Top module: `sbus_core`

## Requirements
- R1: While rst_ni is low, mem_rd_o and mem_wr_o are 0 and mem_addr_o is 0. The first read after reset fetches address 0.
- R2: Fetch reads the word at the PC, loads it into the instruction register and advances the PC by 4. Straight-line code therefore fetches at consecutive word addresses.
- R3: Opcode 1 (move) copies the first source register into the destination. Opcode 9 (load immediate) writes the sign-extended bits 15:0 into the destination. Opcodes 0 and 13 to 15 do nothing beyond the fetch.
- R4: Opcodes 2 to 6 write first-source plus, minus, AND, OR and XOR second-source into the destination, modulo 2^32.
- R5: Only opcodes 2 to 6 update the flags. Zero is set when the result is 0. Carry is the carry out for plus and the no-borrow (first source unsigned greater than or equal to the second) for minus, and is cleared by the logic operations.
- R6: Opcode 7 reads memory at the address held in the first source register and writes the returned word into the destination.
- R7: Opcode 8 writes the second source register to memory at the address held in the first source register.
- R8: Opcode 10 sets the PC to the branch's own address plus 4 plus the sign-extended offset.
- R9: Opcode 11 branches like opcode 10 only when zero is set, and opcode 12 only when carry is set. Otherwise execution continues with the next word.
- R10: Without memory wait cycles, an instruction takes 4 cycles for a move, a load immediate, a no-op or an untaken branch, 5 cycles for a taken branch, and 6 cycles for an ALU operation, a load or a store.
- R11: In every cycle, at most one of PC, immediate, MDR, Z and the register file drives the bus.
- R12: A read or write request stays asserted, with a stable address, until mem_done_i. Read and write are never asserted together. The waiting step adds exactly one cycle per cycle of memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 32 | Byte address of the memory access (MAR) |
| mem_rd_o | output | 1 | Read request, held until completion |
| mem_wr_o | output | 1 | Write request, held until completion |
| mem_wdata_o | output | 32 | Write data (MDR) |
| mem_rdata_i | input | 32 | Read data, sampled on completion |
| mem_done_i | input | 1 | Memory function completed |

## Verification
A read request appears one cycle after the step that issues it. The returned word is captured on the edge where mem_done_i is high. Store data is on mem_wdata_o from the first cycle of mem_wr_o. A branch target appears as the address of the next fetch read. The bench records the cycle of each fetch request and the value seen at each completed write. It compares the gap between successive fetches with the step count of the instruction, plus the configured latency for each memory access. The sweep runs the same program with zero and with three wait cycles per access, so that stalls must add exactly the latency and nothing more.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int REG_IDX_W = 4;
  localparam int IMM_W     = 16;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,  OP_MOV = 4'd1,  OP_ADD = 4'd2,  OP_SUB = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_LD  = 4'd7,
    OP_ST  = 4'd8,  OP_LDI = 4'd9,  OP_BR  = 4'd10, OP_BZ  = 4'd11,
    OP_BC  = 4'd12
  } op_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } alu_op_e;

  typedef struct packed {
    logic                 pc_out;
    logic                 pc_in;
    logic                 ir_in;
    logic                 imm_out;
    logic                 mar_in;
    logic                 mdr_out;
    logic                 mdr_in;
    logic                 y_in;
    logic                 z_in;
    logic                 z_out;
    logic                 sel4;
    logic                 flag_in;
    logic                 rf_out;
    logic                 rf_in;
    logic [REG_IDX_W-1:0] rf_out_sel;
    logic [REG_IDX_W-1:0] rf_in_sel;
    logic                 rd_req;
    logic                 wr_req;
    logic                 wmfc;
    logic                 last;
    alu_op_e              alu_op;
  } ctl_t;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         zero_o
);
  logic [W:0] sum;

  always_comb begin
    sum = '0;
    unique case (op_i)
      ALU_ADD: sum = {1'b0, a_i} + {1'b0, b_i};
      ALU_SUB: sum = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
      ALU_AND: sum = {1'b0, a_i & b_i};
      ALU_OR:  sum = {1'b0, a_i | b_i};
      ALU_XOR: sum = {1'b0, a_i ^ b_i};
      default: sum = '0;
    endcase
  end

  assign res_o   = sum[W-1:0];
  assign carry_o = sum[W];
  assign zero_o  = (sum[W-1:0] == '0);
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W     = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [W-1:0]     rdata_o
);
  localparam int N = 1 << IDX_W;

  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))      regs[g] <= wdata_i;
    end
  end

  assign rdata_o = regs[ridx_i];
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           op_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  input  logic [REG_IDX_W-1:0] ra_idx_i,
  input  logic [REG_IDX_W-1:0] rb_idx_i,
  input  logic                 zf_i,
  input  logic                 cf_i,
  input  logic                 mem_busy_i,
  output ctl_t                 ctl_o,
  output logic [STEP_W-1:0]    step_o
);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] S6 = STEP_W'(6);

  logic [STEP_W-1:0] step_q;
  logic              stall;
  logic              take;
  op_e               op;
  alu_op_e           alu_sel;

  assign op    = op_e'(op_i);
  assign stall = ctl_o.wmfc && mem_busy_i;
  assign take  = (op == OP_BR) || (op == OP_BZ && zf_i) || (op == OP_BC && cf_i);

  always_comb begin
    unique case (op)
      OP_SUB:  alu_sel = ALU_SUB;
      OP_AND:  alu_sel = ALU_AND;
      OP_OR:   alu_sel = ALU_OR;
      OP_XOR:  alu_sel = ALU_XOR;
      default: alu_sel = ALU_ADD;
    endcase
  end

  always_comb begin
    ctl_o        = '0;
    ctl_o.alu_op = ALU_ADD;
    if (step_q == S1) begin
      ctl_o.pc_out = 1'b1;
      ctl_o.mar_in = 1'b1;
      ctl_o.rd_req = 1'b1;
      ctl_o.sel4   = 1'b1;
      ctl_o.z_in   = 1'b1;
    end else if (step_q == S2) begin
      ctl_o.z_out = 1'b1;
      ctl_o.pc_in = 1'b1;
      ctl_o.y_in  = 1'b1;
      ctl_o.wmfc  = 1'b1;
    end else if (step_q == S3) begin
      ctl_o.mdr_out = 1'b1;
      ctl_o.ir_in   = 1'b1;
    end else begin
      unique case (op)
        OP_MOV: begin
          ctl_o.rf_out     = 1'b1;
          ctl_o.rf_out_sel = ra_idx_i;
          ctl_o.rf_in      = 1'b1;
          ctl_o.rf_in_sel  = rd_idx_i;
          ctl_o.last       = 1'b1;
        end
        OP_LDI: begin
          ctl_o.imm_out   = 1'b1;
          ctl_o.rf_in     = 1'b1;
          ctl_o.rf_in_sel = rd_idx_i;
          ctl_o.last      = 1'b1;
        end
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
          if (step_q == S4) begin
            ctl_o.rf_out     = 1'b1;
            ctl_o.rf_out_sel = ra_idx_i;
            ctl_o.y_in       = 1'b1;
          end else if (step_q == S5) begin
            ctl_o.rf_out     = 1'b1;
            ctl_o.rf_out_sel = rb_idx_i;
            ctl_o.alu_op     = alu_sel;
            ctl_o.z_in       = 1'b1;
            ctl_o.flag_in    = 1'b1;
          end else begin
            ctl_o.z_out     = 1'b1;
            ctl_o.rf_in     = 1'b1;
            ctl_o.rf_in_sel = rd_idx_i;
            ctl_o.last      = 1'b1;
          end
        end
        OP_LD: begin
          if (step_q == S4) begin
            ctl_o.rf_out     = 1'b1;
            ctl_o.rf_out_sel = ra_idx_i;
            ctl_o.mar_in     = 1'b1;
            ctl_o.rd_req     = 1'b1;
          end else if (step_q == S5) begin
            ctl_o.wmfc = 1'b1;
          end else begin
            ctl_o.mdr_out   = 1'b1;
            ctl_o.rf_in     = 1'b1;
            ctl_o.rf_in_sel = rd_idx_i;
            ctl_o.last      = 1'b1;
          end
        end
        OP_ST: begin
          if (step_q == S4) begin
            ctl_o.rf_out     = 1'b1;
            ctl_o.rf_out_sel = ra_idx_i;
            ctl_o.mar_in     = 1'b1;
          end else if (step_q == S5) begin
            ctl_o.rf_out     = 1'b1;
            ctl_o.rf_out_sel = rb_idx_i;
            ctl_o.mdr_in     = 1'b1;
            ctl_o.wr_req     = 1'b1;
          end else begin
            ctl_o.wmfc = 1'b1;
            ctl_o.last = 1'b1;
          end
        end
        OP_BR, OP_BZ, OP_BC: begin
          if (step_q == S4) begin
            if (take) begin
              ctl_o.imm_out = 1'b1;
              ctl_o.z_in    = 1'b1;
            end else begin
              ctl_o.last = 1'b1;
            end
          end else begin
            ctl_o.z_out = 1'b1;
            ctl_o.pc_in = 1'b1;
            ctl_o.last  = 1'b1;
          end
        end
        default: ctl_o.last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         step_q <= S1;
    else if (stall)      step_q <= step_q;
    else if (ctl_o.last) step_q <= S1;
    else if (step_q == S6) step_q <= S1;
    else                 step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;
endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_done_i
);
  localparam int N_SRC = 5;

  logic [DATA_W-1:0] pc, ir, mar, mdr, y, z;
  logic [DATA_W-1:0] bus, imm_sx, alu_a, alu_res, rf_rdata;
  logic              zf, cf, alu_c, alu_z;
  logic              rd_pend, wr_pend, mem_busy;
  logic [N_SRC-1:0]  bus_src;
  logic [STEP_W-1:0] step;
  ctl_t              ctl;

  assign imm_sx  = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign bus_src = {ctl.pc_out, ctl.imm_out, ctl.mdr_out, ctl.z_out, ctl.rf_out};

  // AND-OR form of the shared bus; one enable per step
  assign bus = ({DATA_W{ctl.pc_out}}  & pc)
             | ({DATA_W{ctl.imm_out}} & imm_sx)
             | ({DATA_W{ctl.mdr_out}} & mdr)
             | ({DATA_W{ctl.z_out}}   & z)
             | ({DATA_W{ctl.rf_out}}  & rf_rdata);

  assign alu_a    = ctl.sel4 ? DATA_W'(4) : y;
  assign mem_busy = (rd_pend | wr_pend) & ~mem_done_i;

  sbus_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (ir[31:28]),
    .rd_idx_i   (ir[27:24]),
    .ra_idx_i   (ir[23:20]),
    .rb_idx_i   (ir[19:16]),
    .zf_i       (zf),
    .cf_i       (cf),
    .mem_busy_i (mem_busy),
    .ctl_o      (ctl),
    .step_o     (step)
  );

  sbus_alu #(.W(DATA_W)) u_alu (
    .a_i     (alu_a),
    .b_i     (bus),
    .op_i    (ctl.alu_op),
    .res_o   (alu_res),
    .carry_o (alu_c),
    .zero_o  (alu_z)
  );

  sbus_regfile #(.W(DATA_W), .IDX_W(REG_IDX_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl.rf_in),
    .widx_i  (ctl.rf_in_sel),
    .wdata_i (bus),
    .ridx_i  (ctl.rf_out_sel),
    .rdata_o (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= '0; ir <= '0; mar <= '0; y <= '0; z <= '0;
      zf <= 1'b0; cf <= 1'b0;
    end else begin
      if (ctl.pc_in)   pc  <= bus;
      if (ctl.ir_in)   ir  <= bus;
      if (ctl.mar_in)  mar <= bus;
      if (ctl.y_in)    y   <= bus;
      if (ctl.z_in)    z   <= alu_res;
      if (ctl.flag_in) begin
        zf <= alu_z;
        cf <= alu_c;
      end
    end
  end

  // MDR: external side on read completion, bus side otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mdr <= '0;
    else if (rd_pend && mem_done_i)  mdr <= mem_rdata_i;
    else if (ctl.mdr_in)             mdr <= bus;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      if (ctl.rd_req)      rd_pend <= 1'b1;
      else if (mem_done_i) rd_pend <= 1'b0;
      if (ctl.wr_req)      wr_pend <= 1'b1;
      else if (mem_done_i) wr_pend <= 1'b0;
    end
  end

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mdr;
  assign mem_rd_o    = rd_pend;
  assign mem_wr_o    = wr_pend;
endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        bus_src_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              done_i,
  input logic [DATA_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [STEP_W-1:0] step_i,
  input logic              wmfc_i,
  input logic [3:0]        op_i,
  input logic              zf_i,
  input logic              cf_i
);
  logic alu_grp;
  assign alu_grp = (op_i >= 4'd2) && (op_i <= 4'd6);

  AST_ONE_BUS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_src_i)); // R11
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i)); // R12
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> rd_i); // R12
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !done_i |=> wr_i); // R12
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && !done_i |=> $stable(addr_i)); // R12
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !done_i |=> $stable(wdata_i)); // R7
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wmfc_i && (rd_i || wr_i) && !done_i |=> $stable(step_i)); // R12
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i >= STEP_W'(1) && step_i <= STEP_W'(6)); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alu_grp && step_i == STEP_W'(5)) |=> $stable({zf_i, cf_i})); // R5
endmodule

bind sbus_core sbus_core_chk #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_src_i (bus_src),
  .rd_i      (mem_rd_o),
  .wr_i      (mem_wr_o),
  .done_i    (mem_done_i),
  .addr_i    (mem_addr_o),
  .wdata_i   (mem_wdata_o),
  .step_i    (step),
  .wmfc_i    (ctl.wmfc),
  .op_i      (ir[31:28]),
  .zf_i      (zf),
  .cf_i      (cf)
);

// File: tb/sbus_core_bench.sv
module sbus_core_bench;
  localparam int NPROG = 34;
  localparam int NFETCH = 32;
  localparam int NST = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_done;

  always #10 clk = ~clk;

  sbus_core u_sbus_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_done_i  (mem_done)
  );

  logic [31:0] mem [64];
  logic [31:0] prog [NPROG];
  int          exp_idx [NFETCH];
  int          lat, cnt, cyc;
  int          fetch_n, st_n;
  logic [31:0] fetch_addr [40];
  int          fetch_cyc [40];
  logic [31:0] st_addr [16], st_data [16];
  logic        prev_rd;
  int          checks = 0, errors = 0;

  initial begin
    mem_done = 1'b0; mem_rdata = '0; cnt = 0; cyc = 0; prev_rd = 1'b0;
    fetch_n = 0; st_n = 0; lat = 0;
  end

  function automatic logic [31:0] enc(int op, int rd, int ra, int rb, logic [15:0] imm);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // memory model: completion lat cycles after the request is first seen
  always @(negedge clk) begin
    if (!rst_ni) begin
      mem_done = 1'b0; cnt = 0; prev_rd = 1'b0;
    end else begin
      if (mem_rd && !prev_rd && mem_addr < 32'hC0 && fetch_n < 40) begin
        fetch_addr[fetch_n] = mem_addr;
        fetch_cyc[fetch_n]  = cyc;
        fetch_n++;
      end
      prev_rd = mem_rd;
      if ((mem_rd || mem_wr) && !mem_done) begin
        if (cnt == lat) begin
          mem_done = 1'b1;
          cnt = 0;
          if (mem_rd) mem_rdata = mem[mem_addr[7:2]];
          else begin
            mem[mem_addr[7:2]] = mem_wdata;
            if (st_n < 16) begin
              st_addr[st_n] = mem_addr;
              st_data[st_n] = mem_wdata;
            end
            st_n++;
          end
        end else cnt++;
      end else mem_done = 1'b0;
    end
  end

  task automatic load_prog();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    prog[0]  = enc(9, 1, 0, 0, 16'h00C0);   // r1 = 0xC0
    prog[1]  = enc(7, 2, 1, 0, 16'h0);      // r2 = mem[r1]
    prog[2]  = enc(9, 3, 0, 0, 16'hFFFF);   // r3 = -1
    prog[3]  = enc(2, 4, 3, 2, 16'h0);      // r4 = r3 + r2
    prog[4]  = enc(8, 0, 1, 4, 16'h0);      // st r4
    prog[5]  = enc(12, 0, 0, 0, 16'h0004);  // bc taken
    prog[6]  = enc(8, 0, 1, 3, 16'h0);      // skipped
    prog[7]  = enc(3, 5, 2, 2, 16'h0);      // r5 = 0
    prog[8]  = enc(11, 0, 0, 0, 16'h0004);  // bz taken
    prog[9]  = enc(8, 0, 1, 3, 16'h0);      // skipped
    prog[10] = enc(1, 6, 2, 0, 16'h0);      // r6 = r2
    prog[11] = enc(6, 7, 6, 3, 16'h0);      // r7 = r6 ^ r3
    prog[12] = enc(11, 0, 0, 0, 16'h0004);  // bz not taken
    prog[13] = enc(8, 0, 1, 7, 16'h0);
    prog[14] = enc(12, 0, 0, 0, 16'h0004);  // bc not taken
    prog[15] = enc(8, 0, 1, 5, 16'h0);
    prog[16] = enc(4, 8, 7, 2, 16'h0);      // r8 = r7 & r2
    prog[17] = enc(5, 9, 8, 2, 16'h0);      // r9 = r8 | r2
    prog[18] = enc(15, 0, 0, 0, 16'h0);     // unassigned opcode
    prog[19] = enc(8, 0, 1, 9, 16'h0);
    prog[20] = enc(3, 10, 8, 2, 16'h0);     // r10 = r8 - r2 (borrow)
    prog[21] = enc(12, 0, 0, 0, 16'h0004);  // bc not taken
    prog[22] = enc(8, 0, 1, 10, 16'h0);
    prog[23] = enc(9, 11, 0, 0, 16'h7FFF);
    prog[24] = enc(8, 0, 1, 11, 16'h0);
    prog[25] = enc(3, 12, 11, 11, 16'h0);   // Z=1
    prog[26] = enc(9, 13, 0, 0, 16'h0);     // flags untouched
    prog[27] = enc(1, 14, 11, 0, 16'h0);    // flags untouched
    prog[28] = enc(11, 0, 0, 0, 16'h0004);  // bz taken
    prog[29] = enc(8, 0, 1, 3, 16'h0);      // skipped
    prog[30] = enc(9, 2, 0, 0, 16'h00C4);
    prog[31] = enc(7, 15, 2, 0, 16'h0);     // r15 = mem[0xC4]
    prog[32] = enc(8, 0, 1, 15, 16'h0);
    prog[33] = enc(10, 0, 0, 0, 16'hFFFC);  // br to self
    for (int i = 0; i < NPROG; i++) mem[i] = prog[i];
    mem[48] = 32'h0000_1234;
    mem[49] = 32'hA5A5_0F0F;
  endtask

  function automatic string fetch_tag(int k);
    int op;
    if (k == 0) return "R1";
    op = int'(prog[exp_idx[k-1]][31:28]);
    if (op == 10) return "R8";
    if (op == 11 || op == 12) return "R9 R5";
    return "R2";
  endfunction

  task automatic run(int lat_v);
    int wd;
    logic [31:0] exp_d [NST];
    logic [31:0] exp_a [NST];
    string       tag [NST];
    rst_ni = 1'b0;
    lat = lat_v;
    load_prog();
    repeat (3) @(negedge clk);
    fetch_n = 0; st_n = 0;
    chk(!mem_rd && !mem_wr, "R1 req idle in reset", {30'b0, mem_rd, mem_wr}, 32'h0);
    chk(mem_addr == 32'h0, "R1 addr in reset", mem_addr, 32'h0);
    rst_ni = 1'b1;
    wd = 0;
    while (fetch_n < NFETCH && wd < 3000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 3000) chk(1'b0, "watchdog", fetch_n, NFETCH);

    for (int k = 0; k < NFETCH && k < fetch_n; k++)
      chk(fetch_addr[k] == exp_idx[k] * 4, fetch_tag(k), fetch_addr[k], exp_idx[k] * 4);

    for (int k = 0; k + 1 < NFETCH && k + 1 < fetch_n; k++) begin
      int op, steps, memops;
      bit taken;
      op     = int'(prog[exp_idx[k]][31:28]);
      taken  = exp_idx[k+1] != exp_idx[k] + 1;
      memops = (op == 7 || op == 8) ? 2 : 1;
      if (op >= 2 && op <= 8 && op != 1) steps = 6;
      else if (op >= 10 && op <= 12) steps = taken ? 5 : 4;
      else steps = 4;
      chk(fetch_cyc[k+1] - fetch_cyc[k] == steps + lat * memops, "R10 R12 step count",
          fetch_cyc[k+1] - fetch_cyc[k], steps + lat * memops);
    end

    exp_d[0] = 32'h1234 + 32'hFFFF_FFFF;               tag[0] = "R4 R11 add";
    exp_d[1] = 32'h1234 ^ 32'hFFFF_FFFF;               tag[1] = "R4 xor";
    exp_d[2] = 32'h1234 - 32'h1234;                    tag[2] = "R4 sub";
    exp_d[3] = ((32'h1234 ^ 32'hFFFF_FFFF) & 32'h1234) | 32'h1234; tag[3] = "R4 and/or";
    exp_d[4] = 32'h0 - 32'h1234;                       tag[4] = "R4 sub borrow";
    exp_d[5] = 32'h0000_7FFF;                          tag[5] = "R3 ldi";
    exp_d[6] = 32'hA5A5_0F0F;                          tag[6] = "R6 load";
    for (int i = 0; i < NST; i++) exp_a[i] = 32'hC0;
    chk(st_n == NST, "R9 store count", st_n, NST);
    for (int i = 0; i < NST && i < st_n; i++) begin
      chk(st_addr[i] == exp_a[i], "R7 store addr", st_addr[i], exp_a[i]);
      chk(st_data[i] == exp_d[i], tag[i], st_data[i], exp_d[i]);
    end
  endtask

  initial begin
    int n;
    n = 0;
    for (int i = 0; i < NPROG; i++)
      if (i != 6 && i != 9 && i != 29) begin
        exp_idx[n] = i;
        n++;
      end
    exp_idx[n] = 33;
    run(0);
    run(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule